// File: doc/BRIEF.md
# Blink and Heartbeat Duty Modulator

This block sits in front of the duty comparator of one PWM channel and decides which duty value the comparator sees in each PWM cycle. With blinking off it passes duty value A straight through. In blink mode it alternates between A and B, dwelling a programmable number of PWM cycles on each. In heartbeat mode it ramps the duty in equal steps from A toward B and back, producing a triangular brightness sweep.

The block advances only when the phase counter signals the start of a PWM cycle. The same two timing inputs serve both modulated modes with different meanings. In blink mode they are the dwell lengths of the A and B phases. In heartbeat mode one sets how many PWM cycles pass between steps and the other sets the step size. Dropping the counter enable, or changing the mode bits, returns the block to duty A with its counting restarted.

Top module: `duty_modulator`

## Requirements
- R1: While `blink_en_i` is 0 (steady mode), `duty_o` equals `duty_a_i` in the same cycle, whatever `hbeat_en_i`, the strobe or the timing inputs do.
- R2: In blink mode (`blink_en_i`=1, `hbeat_en_i`=0), `duty_o` shows `duty_a_i` for `dwell_x_i`+1 cycle-start strobes, then `duty_b_i` for `dwell_y_i`+1 strobes, and repeats. The change takes effect in the cycle after the clock edge that samples the last strobe of a phase.
- R3: In heartbeat mode (both enables 1), `duty_o` starts at `duty_a_i` and moves toward `duty_b_i` by `dwell_y_i`+1 units after every `dwell_x_i`+1 strobes.
- R4: The heartbeat ramp rises when B is above A and falls when B is below A.
- R5: A heartbeat step that would reach or pass B lands exactly on B and turns the ramp back toward A. A step on the way back that would reach or pass A lands exactly on A and turns the ramp toward B again.
- R6: In heartbeat mode with A equal to B, `duty_o` stays at A.
- R7: Clock edges without `cycle_start_i` leave `duty_o` unchanged in the blink and heartbeat modes.
- R8: While `cntr_en_i` is 0, `duty_o` equals `duty_a_i` and strobes are ignored. After the enable returns, the sequence restarts from the beginning of the A phase with a full dwell count.
- R9: A change of `blink_en_i` or `hbeat_en_i` makes `duty_o` equal `duty_a_i` in that same cycle and restarts the new mode from its beginning. A strobe in that cycle is not counted.
- R10: After reset, with blink disabled, `duty_o` equals `duty_a_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cntr_en_i | input | 1 | Phase counter enable; low holds the block at duty A |
| cycle_start_i | input | 1 | One-cycle strobe at the start of each PWM cycle |
| blink_en_i | input | 1 | Enables blink or heartbeat modulation |
| hbeat_en_i | input | 1 | Selects heartbeat ramp instead of blink when blinking is on |
| duty_a_i | input | 16 | Duty value A (steady value, ramp start) |
| duty_b_i | input | 16 | Duty value B (second blink value, ramp end) |
| dwell_x_i | input | 16 | Blink: A dwell minus one; heartbeat: strobes between steps minus one |
| dwell_y_i | input | 16 | Blink: B dwell minus one; heartbeat: step size minus one |
| duty_o | output | 16 | Effective duty cycle for the channel comparator |

## Verification
Two latencies are due. Mode changes, enable removal and steady mode reach `duty_o` in the same cycle, because the output forces A without waiting for a clock. A strobe moves the modulated output one edge later, because the dwell counter, blink phase and ramp are registered. The bench drives every input on the falling edge and samples on a later falling edge. A strobe raised at one falling edge is therefore sampled by exactly one rising edge, and its effect is read at the next falling edge. Expected values come from the strobe count: a position within the blink period, or a level within the triangle period.

// File: rtl/dm_pkg.sv
package dm_pkg;

  typedef enum logic [1:0] {
    MODE_STEADY = 2'd0,
    MODE_BLINK  = 2'd1,
    MODE_HEART  = 2'd2
  } dm_mode_e;

  function automatic dm_mode_e decode_mode(input logic blink_en, input logic hbeat_en);
    if (!blink_en)     return MODE_STEADY;
    else if (hbeat_en) return MODE_HEART;
    else               return MODE_BLINK;
  endfunction

endpackage

// File: rtl/dm_mode_ctrl.sv
module dm_mode_ctrl
  import dm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cntr_en_i,
  input  logic     cycle_start_i,
  input  logic     blink_en_i,
  input  logic     hbeat_en_i,
  output dm_mode_e mode_o,
  output logic     restart_o,
  output logic     tick_o
);

  dm_mode_e mode_now;
  dm_mode_e mode_q;
  dm_mode_e mode_d;

  always_comb begin
    mode_now  = decode_mode(blink_en_i, hbeat_en_i);
    mode_d    = mode_now;
    restart_o = !cntr_en_i || (mode_now != mode_q) || (mode_now == MODE_STEADY);
    tick_o    = cycle_start_i && !restart_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_STEADY;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_now;

  // A tick is never issued in a cycle whose mode differs from the last one.
  assert_tick_after_settle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (mode_o == mode_q) && cntr_en_i);

endmodule

// File: rtl/dm_dwell_cnt.sv
module dm_dwell_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    wrap_o = tick_i && (cnt_q >= limit_i);
    cnt_en = clear_i || tick_i;
    cnt_d  = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Count moves only on a PWM cycle strobe or a restart.
  assert_cnt_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

  assert_cnt_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/dm_ramp.sv
module dm_ramp #(
  parameter int DUTY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              step_i,
  input  logic [DUTY_W-1:0] duty_a_i,
  input  logic [DUTY_W-1:0] duty_b_i,
  input  logic [DUTY_W-1:0] step_m1_i,
  output logic [DUTY_W-1:0] level_o
);

  localparam int WIDE_W = DUTY_W + 1;

  logic [DUTY_W-1:0] level_q, level_d;
  logic              toward_b_q, toward_b_d;
  logic              ramp_en;
  logic [DUTY_W-1:0] target;
  logic [WIDE_W-1:0] step_w;
  logic [WIDE_W-1:0] up_sum;
  logic [WIDE_W-1:0] down_lim;
  logic              rising;
  logic              hit;

  always_comb begin
    target   = toward_b_q ? duty_b_i : duty_a_i;
    step_w   = {1'b0, step_m1_i} + WIDE_W'(1);
    up_sum   = {1'b0, level_q} + step_w;
    down_lim = {1'b0, target} + step_w;
    rising   = target > level_q;
    hit      = rising ? (up_sum >= {1'b0, target}) : ({1'b0, level_q} <= down_lim);

    ramp_en    = restart_i || step_i;
    level_d    = level_q;
    toward_b_d = toward_b_q;
    if (restart_i) begin
      level_d    = duty_a_i;
      toward_b_d = 1'b1;
    end else if (step_i) begin
      if (hit) begin
        level_d    = target;
        toward_b_d = !toward_b_q;
      end else if (rising) begin
        level_d = up_sum[DUTY_W-1:0];
      end else begin
        level_d = level_q - step_w[DUTY_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q    <= '0;
      toward_b_q <= 1'b1;
    end else if (ramp_en) begin
      level_q    <= level_d;
      toward_b_q <= toward_b_d;
    end
  end

  assign level_o = level_q;

  assert_ramp_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i) |=> $stable(level_q));

  assert_ramp_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (level_q == $past(duty_a_i)) && toward_b_q);

  // With equal end points a step cannot move the level off them.
  assert_ramp_flat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && duty_a_i == duty_b_i && level_q == duty_a_i)
      |=> level_q == $past(duty_a_i));

endmodule

// File: rtl/duty_modulator.sv
module duty_modulator
  import dm_pkg::*;
#(
  parameter int DUTY_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cntr_en_i,
  input  logic              cycle_start_i,
  input  logic              blink_en_i,
  input  logic              hbeat_en_i,
  input  logic [DUTY_W-1:0] duty_a_i,
  input  logic [DUTY_W-1:0] duty_b_i,
  input  logic [CNT_W-1:0]  dwell_x_i,
  input  logic [CNT_W-1:0]  dwell_y_i,
  output logic [DUTY_W-1:0] duty_o
);

  dm_mode_e          mode;
  logic              restart;
  logic              tick;
  logic              wrap;
  logic [CNT_W-1:0]  limit;
  logic              on_b_q, on_b_d, on_b_en;
  logic              ramp_step;
  logic [DUTY_W-1:0] ramp_level;
  logic [DUTY_W-1:0] ramp_inc;

  dm_mode_ctrl u_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cntr_en_i     (cntr_en_i),
    .cycle_start_i (cycle_start_i),
    .blink_en_i    (blink_en_i),
    .hbeat_en_i    (hbeat_en_i),
    .mode_o        (mode),
    .restart_o     (restart),
    .tick_o        (tick)
  );

  // Heartbeat steps every X+1 strobes; blink dwells X+1 on A and Y+1 on B.
  always_comb begin
    limit = dwell_x_i;
    if (mode == MODE_BLINK && on_b_q) limit = dwell_y_i;
  end

  dm_dwell_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart),
    .tick_i  (tick),
    .limit_i (limit),
    .wrap_o  (wrap)
  );

  generate
    if (CNT_W >= DUTY_W) begin : g_inc_trunc
      assign ramp_inc = dwell_y_i[DUTY_W-1:0];
    end else begin : g_inc_ext
      assign ramp_inc = {{(DUTY_W-CNT_W){1'b0}}, dwell_y_i};
    end
  endgenerate

  assign ramp_step = wrap && (mode == MODE_HEART);

  dm_ramp #(.DUTY_W(DUTY_W)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (ramp_step),
    .duty_a_i  (duty_a_i),
    .duty_b_i  (duty_b_i),
    .step_m1_i (ramp_inc),
    .level_o   (ramp_level)
  );

  // Blink phase: 0 shows A, 1 shows B.
  always_comb begin
    on_b_en = restart || (wrap && mode == MODE_BLINK);
    on_b_d  = restart ? 1'b0 : !on_b_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      on_b_q <= 1'b0;
    else if (on_b_en) on_b_q <= on_b_d;
  end

  always_comb begin
    duty_o = duty_a_i;
    if (!restart) begin
      unique case (mode)
        MODE_BLINK: duty_o = on_b_q ? duty_b_i : duty_a_i;
        MODE_HEART: duty_o = ramp_level;
        default:    duty_o = duty_a_i;
      endcase
    end
  end

  assert_steady_is_a_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blink_en_i |-> duty_o == duty_a_i);

  assert_disabled_is_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cntr_en_i |-> duty_o == duty_a_i);

  assert_phase_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cycle_start_i && cntr_en_i && $stable(blink_en_i) && $stable(hbeat_en_i))
      |=> $stable(on_b_q));

  assert_blink_values_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_en_i && !hbeat_en_i) |-> (duty_o == duty_a_i || duty_o == duty_b_i));

endmodule

// File: tb/tb_duty_modulator.sv
module tb_duty_modulator;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cntr_en;
  logic        cyc;
  logic        blink_en;
  logic        hbeat_en;
  logic [15:0] da, db, px, py;
  logic [15:0] duty;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_modulator dut (
    .clk_i(clk), .rst_ni(rst_n), .cntr_en_i(cntr_en), .cycle_start_i(cyc),
    .blink_en_i(blink_en), .hbeat_en_i(hbeat_en), .duty_a_i(da), .duty_b_i(db),
    .dwell_x_i(px), .dwell_y_i(py), .duty_o(duty)
  );

  task automatic check(input string req, input logic [15:0] exp);
    #1;
    checks++;
    if (duty !== exp) begin
      errors++;
      $display("FAIL %s: duty_o actual=%h expected=%h at %0t", req, duty, exp, $time);
    end
  endtask

  task automatic pulse();
    @(negedge clk) cyc = 1'b1;
    @(negedge clk) cyc = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic b, input logic h);
    @(negedge clk);
    blink_en = b;
    hbeat_en = h;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10", 16'h7FFF);
  endtask

  task automatic t_steady();
    set_mode(1'b0, 1'b1);
    da = 16'h1234; db = 16'h5678; px = 16'd0; py = 16'd3;
    for (int n = 0; n < 4; n++) begin
      pulse();
      check("R1", 16'h1234);
    end
  endtask

  task automatic t_blink();
    set_mode(1'b0, 1'b0);
    da = 16'h1000; db = 16'h2000; px = 16'd2; py = 16'd1;
    set_mode(1'b1, 1'b0);
    check("R2", 16'h1000);
    for (int n = 1; n <= 11; n++) begin
      pulse();
      check("R2", ((n % 5) < 3) ? 16'h1000 : 16'h2000);
    end
  endtask

  task automatic t_heart_up();
    logic [15:0] offs [4];
    offs = '{16'd0, 16'd8, 16'd16, 16'd8};
    set_mode(1'b0, 1'b0);
    da = 16'h0100; db = 16'h0110; px = 16'd1; py = 16'd7;
    set_mode(1'b1, 1'b1);
    check("R3", 16'h0100);
    for (int n = 1; n <= 12; n++) begin
      pulse();
      check("R3 R5", 16'h0100 + offs[(n / 2) % 4]);
    end
  endtask

  task automatic t_heart_down();
    logic [15:0] offs [4];
    offs = '{16'd0, 16'd10, 16'd16, 16'd6};
    set_mode(1'b0, 1'b0);
    da = 16'h0200; db = 16'h01F0; px = 16'd0; py = 16'd9;
    set_mode(1'b1, 1'b1);
    check("R4", 16'h0200);
    for (int n = 1; n <= 9; n++) begin
      pulse();
      check("R4 R5", 16'h0200 - offs[n % 4]);
    end
  endtask

  task automatic t_equal();
    set_mode(1'b0, 1'b0);
    da = 16'h0444; db = 16'h0444; px = 16'd0; py = 16'd2;
    set_mode(1'b1, 1'b1);
    for (int n = 0; n < 5; n++) begin
      pulse();
      check("R6", 16'h0444);
    end
  endtask

  task automatic t_no_strobe();
    set_mode(1'b0, 1'b0);
    da = 16'h0011; db = 16'h0022; px = 16'd0; py = 16'd0;
    set_mode(1'b1, 1'b0);
    idle(6);
    check("R7", 16'h0011);
    pulse();
    check("R7", 16'h0022);
    idle(5);
    check("R7", 16'h0022);
  endtask

  task automatic t_enable();
    set_mode(1'b0, 1'b0);
    da = 16'h0A00; db = 16'h0B00; px = 16'd1; py = 16'd3;
    set_mode(1'b1, 1'b0);
    pulse(); pulse();
    check("R8", 16'h0B00);
    @(negedge clk) cntr_en = 1'b0;
    check("R8", 16'h0A00);
    pulse(); pulse(); pulse();
    check("R8", 16'h0A00);
    @(negedge clk) cntr_en = 1'b1;
    @(negedge clk);
    pulse();
    check("R8", 16'h0A00);
    pulse();
    check("R8", 16'h0B00);
  endtask

  task automatic t_mode_change();
    set_mode(1'b0, 1'b0);
    da = 16'h0300; db = 16'h0340; px = 16'd0; py = 16'd15;
    set_mode(1'b1, 1'b1);
    pulse(); pulse();
    check("R9", 16'h0320);
    // Strobe coincides with the mode switch and must not count.
    @(negedge clk);
    hbeat_en = 1'b0;
    cyc = 1'b1;
    check("R9", 16'h0300);
    @(negedge clk) cyc = 1'b0;
    check("R9", 16'h0300);
    pulse();
    check("R9", 16'h0340);
  endtask

  initial begin
    rst_n = 1'b0; cntr_en = 1'b1; cyc = 1'b0; blink_en = 1'b0; hbeat_en = 1'b0;
    da = 16'h7FFF; db = 16'h7FFF; px = 16'd0; py = 16'd0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_steady();
    t_blink();
    t_heart_up();
    t_heart_down();
    t_equal();
    t_no_strobe();
    t_enable();
    t_mode_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule